// File: doc/BRIEF.md
# Programmable AND-OR Logic Array

This block is a configurable two-level sum-of-products network. Each product term is the AND of any set of literals picked from the inputs, where every input offers its true and its inverted form. Each output is the OR of any set of product terms. The input count, term count and output count are three separate parameters, so a term count larger or smaller than the input count is allowed. After configuration the evaluation path holds no registers: the outputs follow the inputs combinationally.

The connection bits arrive one per clock on a serial pin while a load strobe is high. A variant parameter selects one of three forms. The full form programs both planes. The decoder form fixes the AND plane to every minterm of the inputs and loads only the OR plane. The fixed-OR form loads only the AND plane, and each output ORs a fixed group of adjacent terms. The outputs stay at zero until a complete configuration has been shifted in.

Top module: `pla_array`

## Requirements
- R1: After reset, every output reads 0 for any input until a full configuration has been loaded.
- R2: While `cfgLoad` is high, each clock shifts in `cfgBit`, least significant bit first, so the first bit sent becomes configuration bit 0. In the full form, AND bit `t*2*NUM_IN + 2*i + p` connects input `i` to term `t` (p=0 is the true form, p=1 the inverted form). OR bit `T*2*NUM_IN + o*T + t` connects term `t` to output `o`, where T is the term count.
- R3: A product term is 1 exactly when every literal connected to it is 1. The outputs change with `dataIn` without waiting for a clock edge.
- R4: A product term with no connected literal evaluates to 0.
- R5: An output is the OR of its connected terms, and an output with no connected term reads 0.
- R6: If `cfgLoad` falls before a full configuration length of bits has been shifted, the outputs stay at 0.
- R7: While `cfgLoad` is high, and in the cycle after it falls, every output reads 0. The new configuration takes effect once the full-length load has finished.
- R8: In the decoder form there are 2^NUM_IN terms, term `t` is 1 exactly when `dataIn` equals `t`, and only the OR plane is loaded, at bit `o*2^NUM_IN + t`.
- R9: In the fixed-OR form only the AND plane is loaded, using the bit positions of R2, and output `o` ORs terms `o*G` to `o*G+G-1`, where G = NUM_TERMS/NUM_OUT.
- R10: With inputs a, b, c on `dataIn[0..2]` and the array set up as w=(a&c)|(!b&!c), x=(a&b&c)|(!b&!c) and y=a&b&c on `dataOut[0..2]`, all eight input combinations match those equations.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the configuration logic |
| rst | input | 1 | Synchronous reset, active high |
| cfgLoad | input | 1 | Load strobe; shifts one configuration bit per clock while high |
| cfgBit | input | 1 | Serial configuration bit |
| dataIn | input | NUM_IN | Logic inputs |
| dataOut | output | NUM_OUT | Sum-of-products outputs |

## Verification
A wrong connection bit, or a bit shifted into the wrong position, shows at the outputs only for the input combinations where that literal or term decides the result. For this reason every input combination is compared with a model built from the loaded bits as soon as the load has completed. A faulty load counter or completion flag shows as outputs that become active after a short load, or that remain at zero after a full load, in the cycle after the strobe falls. A fault in the literal polarity or in the empty-term handling shows at once, combinationally, for the affected inputs.

// File: rtl/pla_pkg.sv
package pla_pkg;
  typedef enum logic [1:0] {
    PLA_FULL     = 2'd0,
    PLA_DECODER  = 2'd1,
    PLA_FIXED_OR = 2'd2
  } plaMode_t;

  typedef struct packed {
    logic shiftEn;
    logic outEn;
  } ctrlStrb_t;
endpackage

// File: rtl/pla_ctrl.sv
module pla_ctrl #(
  parameter int CFG_W = 36
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                cfgLoad,
  output pla_pkg::ctrlStrb_t  strb
);
  localparam int CW = $clog2(CFG_W + 1);

  logic [CW-1:0] cnt;
  logic          loadPrev;
  logic          done;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt      <= '0;
      loadPrev <= 1'b0;
      done     <= 1'b0;
    end else begin
      loadPrev <= cfgLoad;
      if (cfgLoad) begin
        done <= 1'b0;
        if (!loadPrev) cnt <= CW'(1);
        else if (cnt != CW'(CFG_W)) cnt <= cnt + 1'b1;
      end else if (loadPrev) begin
        done <= (cnt == CW'(CFG_W));
      end
    end
  end

  always_comb begin
    strb.shiftEn = cfgLoad;
    strb.outEn   = done && !cfgLoad;
  end

  // R2: consecutive load cycles advance the bit count by one until full
  a_r2_count_step: assert property (@(posedge clk) disable iff (rst)
    ($past(cfgLoad) && $past(loadPrev) && ($past(cnt) < CW'(CFG_W))) |-> (cnt == $past(cnt) + 1'b1));
  // R6: completion only after a full-length burst
  a_r6_full_burst: assert property (@(posedge clk) disable iff (rst)
    $rose(done) |-> ($past(cnt) == CW'(CFG_W)));
  // R7: any load cycle clears completion
  a_r7_load_clears: assert property (@(posedge clk) disable iff (rst)
    $past(cfgLoad) |-> !done);
endmodule

// File: rtl/pla_datapath.sv
module pla_datapath #(
  parameter pla_pkg::plaMode_t MODE = pla_pkg::PLA_FULL,
  parameter int NUM_IN   = 3,
  parameter int TERMS    = 4,
  parameter int NUM_OUT  = 3,
  parameter int AND_BITS = 24,
  parameter int CFG_W    = 36
) (
  input  logic                clk,
  input  logic                rst,
  input  pla_pkg::ctrlStrb_t  strb,
  input  logic                cfgBit,
  input  logic [NUM_IN-1:0]   dataIn,
  output logic [NUM_OUT-1:0]  dataOut
);
  localparam int LIT_W = 2 * NUM_IN;
  localparam int GRP   = TERMS / NUM_OUT;

  logic [CFG_W-1:0]   cfgReg;
  logic [LIT_W-1:0]   lits;
  logic [TERMS-1:0]   termHit;
  logic [NUM_OUT-1:0] orOut;

  always_ff @(posedge clk) begin
    if (rst) cfgReg <= '0;
    else if (strb.shiftEn) cfgReg <= {cfgBit, cfgReg[CFG_W-1:1]};
  end

  for (genvar i = 0; i < NUM_IN; i++) begin : g_lit
    assign lits[2*i]   = dataIn[i];
    assign lits[2*i+1] = ~dataIn[i];
  end

  if (MODE == pla_pkg::PLA_DECODER) begin : g_and_fixed
    for (genvar t = 0; t < TERMS; t++) begin : g_term
      assign termHit[t] = (dataIn == NUM_IN'(t));
    end
  end else begin : g_and_prog
    for (genvar t = 0; t < TERMS; t++) begin : g_term
      logic [LIT_W-1:0] mask;
      assign mask       = cfgReg[t*LIT_W +: LIT_W];
      assign termHit[t] = (|mask) && ((mask & ~lits) == '0);
    end
  end

  if (MODE == pla_pkg::PLA_FIXED_OR) begin : g_or_fixed
    for (genvar o = 0; o < NUM_OUT; o++) begin : g_out
      assign orOut[o] = |termHit[o*GRP +: GRP];
    end
  end else begin : g_or_prog
    for (genvar o = 0; o < NUM_OUT; o++) begin : g_out
      assign orOut[o] = |(termHit & cfgReg[AND_BITS + o*TERMS +: TERMS]);
    end
  end

  assign dataOut = strb.outEn ? orOut : '0;

  // R5: no active term means no active output
  a_r5_no_term_no_out: assert property (@(posedge clk) disable iff (rst)
    (termHit == '0) |-> (dataOut == '0));
endmodule

// File: rtl/pla_array.sv
module pla_array #(
  parameter pla_pkg::plaMode_t MODE = pla_pkg::PLA_FULL,
  parameter int NUM_IN    = 3,
  parameter int NUM_TERMS = 4,
  parameter int NUM_OUT   = 3
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               cfgLoad,
  input  logic               cfgBit,
  input  logic [NUM_IN-1:0]  dataIn,
  output logic [NUM_OUT-1:0] dataOut
);
  localparam int TERMS    = (MODE == pla_pkg::PLA_DECODER) ? (1 << NUM_IN) : NUM_TERMS;
  localparam int AND_BITS = (MODE == pla_pkg::PLA_DECODER) ? 0 : TERMS * 2 * NUM_IN;
  localparam int OR_BITS  = (MODE == pla_pkg::PLA_FIXED_OR) ? 0 : TERMS * NUM_OUT;
  localparam int CFG_W    = AND_BITS + OR_BITS;

  pla_pkg::ctrlStrb_t strb;

  pla_ctrl #(.CFG_W(CFG_W)) u_ctrl (
    .clk(clk), .rst(rst), .cfgLoad(cfgLoad), .strb(strb)
  );

  pla_datapath #(
    .MODE(MODE), .NUM_IN(NUM_IN), .TERMS(TERMS), .NUM_OUT(NUM_OUT),
    .AND_BITS(AND_BITS), .CFG_W(CFG_W)
  ) u_dp (
    .clk(clk), .rst(rst), .strb(strb), .cfgBit(cfgBit),
    .dataIn(dataIn), .dataOut(dataOut)
  );

  // R7: outputs blank while loading and one cycle after
  a_r7_quiet_load: assert property (@(posedge clk) disable iff (rst)
    $past(cfgLoad) |-> (dataOut == '0));
  // R1: outputs blank in the first cycle after reset
  a_r1_reset_quiet: assert property (@(posedge clk)
    $past(rst) |-> (dataOut == '0));
endmodule

// File: tb/pla_array_tb.sv
module pla_array_tb;
  logic clk = 1'b0;
  logic rst = 1'b1;
  always #5 clk = ~clk;

  logic       mLoad = 0, mBit = 0;  logic [2:0] mIn = 0; logic [2:0] mOut;
  logic       dLoad = 0, dBit = 0;  logic [2:0] dIn = 0; logic [1:0] dOut;
  logic       fLoad = 0, fBit = 0;  logic [2:0] fIn = 0; logic [1:0] fOut;

  pla_array #(.MODE(pla_pkg::PLA_FULL), .NUM_IN(3), .NUM_TERMS(4), .NUM_OUT(3)) u_dut (
    .clk(clk), .rst(rst), .cfgLoad(mLoad), .cfgBit(mBit), .dataIn(mIn), .dataOut(mOut));
  pla_array #(.MODE(pla_pkg::PLA_DECODER), .NUM_IN(3), .NUM_TERMS(8), .NUM_OUT(2)) u_dec (
    .clk(clk), .rst(rst), .cfgLoad(dLoad), .cfgBit(dBit), .dataIn(dIn), .dataOut(dOut));
  pla_array #(.MODE(pla_pkg::PLA_FIXED_OR), .NUM_IN(3), .NUM_TERMS(4), .NUM_OUT(2)) u_for (
    .clk(clk), .rst(rst), .cfgLoad(fLoad), .cfgBit(fBit), .dataIn(fIn), .dataOut(fOut));

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  // {input c b a, expected y x w} for R10
  localparam logic [5:0] VEC [8] = '{
    6'b000_011, 6'b001_011, 6'b010_000, 6'b011_000,
    6'b100_000, 6'b101_001, 6'b110_000, 6'b111_111};

  localparam logic [35:0] CFG_EX = {4'b0100, 4'b0110, 4'b0011,
                                    6'b000000, 6'b010101, 6'b101000, 6'b010001};
  localparam logic [35:0] CFG_SP = {4'b1000, 4'b0000, 4'b0001,
                                    6'b000000, 6'b000000, 6'b000000, 6'b000001};
  localparam logic [15:0] CFG_DC = 16'hA5C3;
  localparam logic [23:0] CFG_FO = {6'b000010, 6'b010000, 6'b000000, 6'b001001};

  task automatic check(input string tag, input logic [2:0] act, input logic [2:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %b expected %b", tag, act, exp);
    end
  endtask

  function automatic logic termOf(input logic [5:0] mask, input logic [2:0] v);
    logic [5:0] lits;
    for (int i = 0; i < 3; i++) begin
      lits[2*i]   = v[i];
      lits[2*i+1] = !v[i];
    end
    return (|mask) && ((mask & ~lits) == 6'b0);
  endfunction

  function automatic logic [2:0] refMain(input logic [35:0] c, input logic [2:0] v);
    logic [2:0] r = '0;
    for (int t = 0; t < 4; t++)
      for (int o = 0; o < 3; o++)
        if (termOf(c[t*6 +: 6], v) && c[24 + o*4 + t]) r[o] = 1'b1;
    return r;
  endfunction

  function automatic logic [2:0] refFor(input logic [23:0] c, input logic [2:0] v);
    logic [2:0] r = '0;
    for (int o = 0; o < 2; o++)
      r[o] = termOf(c[(2*o)*6 +: 6], v) | termOf(c[(2*o+1)*6 +: 6], v);
    return r;
  endfunction

  task automatic loadMain(input logic [35:0] c, input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk); mLoad = 1; mBit = c[k];
      if (k == 5) begin #1; check("R7 zero while loading", mOut, 3'b000); end
    end
    @(negedge clk); mLoad = 0;
    #1 check("R7 zero in cycle after load", mOut, 3'b000);
    @(negedge clk);
  endtask

  task automatic loadDec(input logic [15:0] c);
    for (int k = 0; k < 16; k++) begin @(negedge clk); dLoad = 1; dBit = c[k]; end
    @(negedge clk); dLoad = 0;
    @(negedge clk);
  endtask

  task automatic loadFor(input logic [23:0] c);
    for (int k = 0; k < 24; k++) begin @(negedge clk); fLoad = 1; fBit = c[k]; end
    @(negedge clk); fLoad = 0;
    @(negedge clk);
  endtask

  task automatic finishRun();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      checks++; errors++;
      $display("FAIL watchdog expired");
      finishRun();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    // R1: nothing loaded yet
    for (int v = 0; v < 8; v++) begin
      mIn = 3'(v); #1 check("R1 reset outputs zero", mOut, 3'b000);
    end

    // R6: short burst leaves outputs blank
    loadMain(CFG_EX, 20);
    for (int v = 0; v < 8; v++) begin
      mIn = 3'(v); #1 check("R6 short load keeps zero", mOut, 3'b000);
    end

    // R10, R2, R3: full example configuration, table walk
    loadMain(CFG_EX, 36);
    for (int k = 0; k < 8; k++) begin
      mIn = VEC[k][5:3];
      #1 check("R10 example equations", mOut, VEC[k][2:0]);
      check("R2 R3 model match", mOut, refMain(CFG_EX, VEC[k][5:3]));
    end

    // R4, R5: sparse configuration, empty term and empty output
    loadMain(CFG_SP, 36);
    for (int v = 0; v < 8; v++) begin
      mIn = 3'(v); #1;
      check("R4 R5 sparse config", mOut, {1'b0, 1'b0, v[0]});
      check("R5 model match", mOut, refMain(CFG_SP, 3'(v)));
    end

    // R7: reload then short burst blanks again
    loadMain(CFG_EX, 7);
    mIn = 3'b111; #1 check("R7 R6 aborted reload blanks", mOut, 3'b000);

    // R8: decoder form
    loadDec(CFG_DC);
    for (int v = 0; v < 8; v++) begin
      dIn = 3'(v); #1 check("R8 decoder minterm", {1'b0, dOut}, {1'b0, CFG_DC[8+v], CFG_DC[v]});
    end

    // R9: fixed-OR form
    loadFor(CFG_FO);
    for (int v = 0; v < 8; v++) begin
      fIn = 3'(v); #1;
      check("R9 fixed OR groups", {1'b0, fOut}, refFor(CFG_FO, 3'(v)));
      check("R9 equations", {1'b0, fOut}, {1'b0, v[2] | !v[0], v[0] & !v[1]});
    end

    finishRun();
  end
endmodule